// File: doc/BRIEF.md
# Deferred Invalidation Queue with Read Barrier

This block sits between the coherence bus and the cache state array. Other agents send invalidation requests, each carrying a line address. The block answers each one at once with an acknowledge and records the address in an ordered queue. The queued addresses are then presented to the cache state port and retired one at a time whenever that port is free. Because the acknowledge comes before the invalidation takes effect, the bus is released early and the cost of the state update is hidden.

CPU loads never search this queue. A line with an invalidation still waiting may therefore keep hitting in the cache. When software needs to see every write that other agents have already had acknowledged, it raises a read barrier. The block holds the CPU in a stall until nothing acknowledged before the current cycle remains queued.

Retiring an entry needs no answer from the cache. The address is handed over in the cycle the port is free, and the entry is gone from that clock edge on. It makes no difference whether the line is still valid, already invalid, or not present at all.

Top module: `inval_defer_queue`

## Requirements
- R1: After reset the queue is empty. `apply_valid` is low, and `barrier_stall` stays low even with `rd_barrier` high.
- R2: When fewer than DEPTH entries are held, `inv_ack` equals `inv_valid` in the same cycle, with no wait for any invalidation to be applied.
- R3: An acknowledged address is accepted at that clock edge. If the queue was empty, `apply_valid` is high from the next cycle on, with `apply_addr` equal to that address.
- R4: Entries are presented and retired in the order they were acknowledged.
- R5: An entry retires in a cycle only when `apply_valid` is high and `apply_busy` is low, and at most one entry retires per cycle. While `apply_busy` is high, `apply_valid` stays high and `apply_addr` does not change. A retire needs no response from the cache.
- R6: With DEPTH entries held and no retire in the cycle, `inv_ack` stays low and nothing is accepted. With BYPASS_FULL=1, a request that arrives while the queue is full is acknowledged in a cycle that retires an entry, and the occupancy stays at DEPTH.
- R7: While `rd_barrier` is high, `barrier_stall` is high exactly when at least one acknowledged entry is still queued. It falls in the cycle after the last entry retires.
- R8: While `rd_barrier` is low, `barrier_stall` is low, even with entries queued. An invalidation acknowledged in the same cycle as a barrier does not stall that cycle, but it does stall the following cycles until it retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inv_valid | input | 1 | Invalidation request from the bus |
| inv_addr | input | ADDR_W | Line address of the request |
| inv_ack | output | 1 | Request accepted this cycle |
| apply_valid | output | 1 | Head entry offered to the cache state port |
| apply_addr | output | ADDR_W | Line address of the head entry |
| apply_busy | input | 1 | Cache state port cannot take an update this cycle |
| rd_barrier | input | 1 | CPU read barrier request |
| barrier_stall | output | 1 | CPU must wait; acknowledged entries are still pending |

## Verification
Two events can land in the same cycle: a retire toward the cache state port and a new request arriving while the queue is full. The bench fills all DEPTH entries with the port held busy and keeps a fifth request waiting. It then frees the port, so the retire and the acknowledge coincide. The check confirms that the acknowledge appears in exactly that cycle, that the head advances, that the queue is still full afterwards, and that the newcomer comes out last. The bench also raises a barrier in the same cycle as an acknowledge into an empty queue. It expects no stall in that cycle and a stall in the next.

// File: rtl/ivq_pkg.sv
package ivq_pkg;

   // width of an occupancy counter able to hold 0..depth
   function automatic int ivq_cnt_width(input int depth);
      return $clog2(depth + 1);
   endfunction

   // width of a slot index, never below one bit
   function automatic int ivq_ptr_width(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/ivq_fifo.sv
module ivq_fifo
   import ivq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 4,
   localparam int CNT_W = ivq_cnt_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              pop,
   output logic [ADDR_W-1:0] head_addr,
   output logic [CNT_W-1:0]  occ,
   output logic              full,
   output logic              empty
);

   generate
      if (DEPTH == 1) begin : g_single
         logic              held_q;
         logic [ADDR_W-1:0] slot_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               held_q <= 1'b0;
            else if (push)
               held_q <= 1'b1;
            else if (pop)
               held_q <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (push)
               slot_q <= push_addr;
         end

         assign head_addr = slot_q;
         assign occ       = CNT_W'(held_q);
         assign full      = held_q;
         assign empty     = !held_q;
      end else begin : g_ring
         localparam int PTR_W = ivq_ptr_width(DEPTH);
         localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

         logic [ADDR_W-1:0] mem_q [DEPTH];
         logic [PTR_W-1:0]  wr_q, rd_q;
         logic [CNT_W-1:0]  cnt_q;

         function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
            return (p == LAST) ? '0 : p + 1'b1;
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_q  <= '0;
               rd_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (push)
                  wr_q <= step(wr_q);
               if (pop)
                  rd_q <= step(rd_q);
               if (push && !pop)
                  cnt_q <= cnt_q + 1'b1;
               else if (pop && !push)
                  cnt_q <= cnt_q - 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (push)
               mem_q[wr_q] <= push_addr;
         end

         assign head_addr = mem_q[rd_q];
         assign occ       = cnt_q;
         assign full      = (cnt_q == CNT_W'(DEPTH));
         assign empty     = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/ivq_admit.sv
module ivq_admit #(
   parameter bit BYPASS_FULL = 1'b1
) (
   input  logic inv_valid,
   input  logic full,
   input  logic retire,
   output logic ack
);

   generate
      if (BYPASS_FULL) begin : g_bypass
         // a slot freed by a retire in this cycle can be refilled at once
         assign ack = inv_valid && (!full || retire);
      end else begin : g_strict
         assign ack = inv_valid && !full;
      end
   endgenerate

endmodule

// File: rtl/ivq_barrier.sv
module ivq_barrier (
   input  logic rd_barrier,
   input  logic pending,
   output logic stall
);

   // pending reflects entries acknowledged in earlier cycles only
   assign stall = rd_barrier && pending;

endmodule

// File: rtl/inval_defer_queue.sv
module inval_defer_queue
   import ivq_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DEPTH       = 4,
   parameter bit BYPASS_FULL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_addr,
   output logic              inv_ack,
   output logic              apply_valid,
   output logic [ADDR_W-1:0] apply_addr,
   input  logic              apply_busy,
   input  logic              rd_barrier,
   output logic              barrier_stall
);

   localparam int CNT_W = ivq_cnt_width(DEPTH);

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("inval_defer_queue: ADDR_W must be at least 1");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("inval_defer_queue: DEPTH must be at least 1");
      end
   endgenerate

   logic             q_full, q_empty, retire;
   logic [CNT_W-1:0] occ;

   assign apply_valid = !q_empty;
   assign retire      = apply_valid && !apply_busy;

   ivq_admit #(.BYPASS_FULL(BYPASS_FULL)) u_admit (
      .inv_valid (inv_valid),
      .full      (q_full),
      .retire    (retire),
      .ack       (inv_ack)
   );

   ivq_fifo #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (inv_ack),
      .push_addr (inv_addr),
      .pop       (retire),
      .head_addr (apply_addr),
      .occ       (occ),
      .full      (q_full),
      .empty     (q_empty)
   );

   ivq_barrier u_barrier (
      .rd_barrier (rd_barrier),
      .pending    (apply_valid),
      .stall      (barrier_stall)
   );

endmodule

// File: rtl/ivq_checker.sv
module ivq_checker #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 4,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              inv_valid,
   input logic              inv_ack,
   input logic              apply_valid,
   input logic [ADDR_W-1:0] apply_addr,
   input logic              apply_busy,
   input logic              rd_barrier,
   input logic              barrier_stall,
   input logic [CNT_W-1:0]  occ
);

   // R2
   ack_when_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && (occ < CNT_W'(DEPTH))) |-> inv_ack);

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((occ == CNT_W'(DEPTH)) && !(apply_valid && !apply_busy)) |-> !inv_ack);

   // R3
   ack_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_ack |=> apply_valid);

   // R5
   hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (apply_valid && apply_busy) |=> (apply_valid && $stable(apply_addr)));

   // R7
   stall_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      barrier_stall |-> (rd_barrier && apply_valid));

   // R8
   no_stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_barrier |-> !barrier_stall);

   // R5
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH));

endmodule

bind inval_defer_queue ivq_checker #(
   .ADDR_W (ADDR_W),
   .DEPTH  (DEPTH),
   .CNT_W  (CNT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .inv_valid     (inv_valid),
   .inv_ack       (inv_ack),
   .apply_valid   (apply_valid),
   .apply_addr    (apply_addr),
   .apply_busy    (apply_busy),
   .rd_barrier    (rd_barrier),
   .barrier_stall (barrier_stall),
   .occ           (occ)
);

// File: tb/inval_defer_queue_test.sv
module inval_defer_queue_test;

   localparam int AW = 16;
   localparam int DP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          inv_valid = 1'b0;
   logic [AW-1:0] inv_addr = '0;
   logic          inv_ack;
   logic          apply_valid;
   logic [AW-1:0] apply_addr;
   logic          apply_busy = 1'b1;
   logic          rd_barrier = 1'b0;
   logic          barrier_stall;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;   // 50 MHz

   inval_defer_queue #(.ADDR_W(AW), .DEPTH(DP), .BYPASS_FULL(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ack(inv_ack),
      .apply_valid(apply_valid), .apply_addr(apply_addr), .apply_busy(apply_busy),
      .rd_barrier(rd_barrier), .barrier_stall(barrier_stall)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // drive one request with the port busy; ack expected at once
   task automatic push_one(input logic [AW-1:0] a, input string tag);
      @(negedge clk);
      inv_valid = 1'b1;
      inv_addr  = a;
      #5 chk(inv_ack === 1'b1, tag, int'(inv_ack), 1);
      @(negedge clk);
      inv_valid = 1'b0;
   endtask

   // release the port and expect the listed addresses in order
   task automatic drain(input logic [AW-1:0] exp [], input string tag);
      @(negedge clk);
      apply_busy = 1'b0;
      foreach (exp[i]) begin
         #5 chk(apply_valid === 1'b1 && apply_addr === exp[i], tag, int'(apply_addr), int'(exp[i]));
         @(negedge clk);
      end
      #5 chk(apply_valid === 1'b0, {tag, " empty"}, int'(apply_valid), 0);
      apply_busy = 1'b1;
   endtask

   task automatic t_reset;
      rd_barrier = 1'b1;
      #5;
      chk(apply_valid === 1'b0, "R1 apply_valid", int'(apply_valid), 0);
      chk(barrier_stall === 1'b0, "R1 stall", int'(barrier_stall), 0);
      chk(inv_ack === 1'b0, "R1 ack", int'(inv_ack), 0);
      @(negedge clk);
      rd_barrier = 1'b0;
   endtask

   task automatic t_single;
      @(negedge clk);
      inv_valid = 1'b1;
      inv_addr  = 16'h1234;
      #5;
      chk(inv_ack === 1'b1, "R2 same-cycle ack", int'(inv_ack), 1);
      chk(apply_valid === 1'b0, "R3 not yet visible", int'(apply_valid), 0);
      @(negedge clk);
      inv_valid = 1'b0;
      #5 chk(apply_valid === 1'b1 && apply_addr === 16'h1234, "R3 head",
             int'(apply_addr), 16'h1234);
      drain('{16'h1234}, "R5 single retire");
   endtask

   task automatic t_order;
      push_one(16'hA001, "R2 order push");
      push_one(16'hA002, "R2 order push");
      push_one(16'hA003, "R2 order push");
      repeat (3) begin
         @(negedge clk);
         #5 chk(apply_valid === 1'b1 && apply_addr === 16'hA001, "R5 held while busy",
                int'(apply_addr), 16'hA001);
      end
      drain('{16'hA001, 16'hA002, 16'hA003}, "R4 order");
   endtask

   task automatic t_full;
      for (int i = 0; i < DP; i++) push_one(AW'(16'hB000 + i), "R2 fill");
      @(negedge clk);
      inv_valid = 1'b1;
      inv_addr  = 16'hB0FF;
      #5 chk(inv_ack === 1'b0, "R6 withheld when full", int'(inv_ack), 0);
      @(negedge clk);
      #5 chk(inv_ack === 1'b0, "R6 still withheld", int'(inv_ack), 0);
      chk(apply_addr === 16'hB000, "R6 head unchanged", int'(apply_addr), 16'hB000);
      @(negedge clk);
      apply_busy = 1'b0;
      #5 chk(inv_ack === 1'b1, "R6 ack with same-cycle retire", int'(inv_ack), 1);
      @(negedge clk);
      apply_busy = 1'b1;
      inv_addr   = 16'hB0EE;
      #5;
      chk(inv_ack === 1'b0, "R6 still full after swap", int'(inv_ack), 0);
      chk(apply_addr === 16'hB001, "R4 head advanced", int'(apply_addr), 16'hB001);
      @(negedge clk);
      inv_valid = 1'b0;
      drain('{16'hB001, 16'hB002, 16'hB003, 16'hB0FF}, "R4 full order");
   endtask

   task automatic t_barrier;
      push_one(16'hC001, "R2 barrier push");
      push_one(16'hC002, "R2 barrier push");
      #5 chk(barrier_stall === 1'b0, "R8 no barrier no stall", int'(barrier_stall), 0);
      @(negedge clk);
      rd_barrier = 1'b1;
      #5 chk(barrier_stall === 1'b1, "R7 stall pending", int'(barrier_stall), 1);
      @(negedge clk);
      apply_busy = 1'b0;
      #5 chk(barrier_stall === 1'b1, "R7 stall before last retire", int'(barrier_stall), 1);
      @(negedge clk);
      #5 chk(barrier_stall === 1'b1, "R7 one entry left", int'(barrier_stall), 1);
      @(negedge clk);
      #5 chk(barrier_stall === 1'b0, "R7 released after last retire", int'(barrier_stall), 0);
      apply_busy = 1'b1;
      @(negedge clk);
      rd_barrier = 1'b0;
   endtask

   task automatic t_barrier_meets_ack;
      @(negedge clk);
      rd_barrier = 1'b1;
      inv_valid  = 1'b1;
      inv_addr   = 16'hD00D;
      #5;
      chk(inv_ack === 1'b1, "R8 ack alongside barrier", int'(inv_ack), 1);
      chk(barrier_stall === 1'b0, "R8 no stall same cycle", int'(barrier_stall), 0);
      @(negedge clk);
      inv_valid = 1'b0;
      #5 chk(barrier_stall === 1'b1, "R8 stall next cycle", int'(barrier_stall), 1);
      @(negedge clk);
      apply_busy = 1'b0;
      @(negedge clk);
      #5 chk(barrier_stall === 1'b0, "R7 stall cleared", int'(barrier_stall), 0);
      apply_busy = 1'b1;
      rd_barrier = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_order();
      t_full();
      t_barrier();
      t_barrier_meets_ack();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule